// File: doc/BRIEF.md
# Escalating System Watchdog

This block is a system-management watchdog timer. Software arms it by writing a timeout, expressed in 2-second units, to an 8-bit time register. The block then counts down once per 2-second tick, produced by a prescaler on the core clock. Software services the watchdog by writing the time register again before the count runs out. When the count does run out, the block takes the action chosen in its control register. It can assert a one-cycle system-reset pulse, assert a one-cycle power-off request, or do nothing except record the expiry.

The choice between reset and power-off depends on a retry budget. A 3-bit limit input sets how many consecutive unintentional resets are allowed. The block keeps a count of such resets. This count goes up on every reset the watchdog issues and on every pulse of an input that reports an unintentional reset from another source. When the count has reached the limit, an expiry asks for power-off instead of reset. Software clears the count by writing the control register with its boot-OK bit set.

The register port is a plain address, write strobe, write data and combinational read data. There is no read strobe, so any write counts as a register access.

Top module: `wdog_escalate`

## Requirements
- R1: Reading address 0 (time register) returns the value last written there, never the live down-counter.
- R2: After a write of N (1 to 255) to address 0, the expiry pulse goes high exactly N*TICK_CYCLES+1 clock cycles after the write edge. Each tick of TICK_CYCLES cycles stands for 2 seconds.
- R3: Writing 0 to address 0 expires at once: the pulse goes high 1 cycle after the write edge.
- R4: A new write to address 0 before expiry reloads the count and restarts the prescaler. This suppresses the pending expiry.
- R5: Address 1 (status) ignores writes and reads 0 except after an expiry.
- R6: Address 2 (control) keeps only bit 4 (act), bit 5 (mute) and bit 7 (boot OK); its other bits read 0. Address 3 reads 0.
- R7: An expiry issues an action only when act=1 and mute=0, whatever bit 7 holds. With mute=1 or act=0, neither output pulses.
- R8: On an action expiry, if the consecutive-reset count is below retry_lim_i, sys_rst_o pulses and the count increments. Otherwise pwr_off_o pulses. A limit of 0 always gives power-off. The two outputs are never high together.
- R9: A write to address 2 with bit 7 set clears the consecutive-reset count. Each cycle of unplanned_rst_i high increments the count, which saturates at its maximum.
- R10: Each output pulse lasts one cycle. After expiry the counter stays at 0 and nothing further fires until address 0 is written again.
- R11: From the cycle the expiry output would pulse, status reads 1 (reset issued), 2 (power-off issued) or 3 (expired with no action). It holds this value until the next register write.
- R12: After reset, both outputs are low, all reads return 0 and the counter is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 2 | Register address: 0 time, 1 status, 2 control, 3 unused |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| retry_lim_i | input | RETRY_W | Number of consecutive unintentional resets allowed before power-off |
| unplanned_rst_i | input | 1 | Reports one unintentional reset from another source per cycle high |
| sys_rst_o | output | 1 | One-cycle system-reset request |
| pwr_off_o | output | 1 | One-cycle power-off request |

## Verification
Some properties are checked by assertions on every cycle. These cover the one-cycle width and mutual exclusion of the two outputs, the status code matching the pulse that fired, the reset-versus-power-off decision against the retry count and limit, the count holding still between ticks, the counter staying disarmed until reloaded, and the retry count clearing after a boot-OK write. Other behaviour can only be shown by the bench's scenarios. This includes the exact expiry latency for different reload values, servicing before expiry, the register read-back masks, the consecutive-reset sequence walking from reset to power-off, and the effect of the external unintentional-reset input.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WA_TIME = 2'd0,
    WA_STAT = 2'd1,
    WA_CTRL = 2'd2,
    WA_RSVD = 2'd3
  } wd_addr_e;

  localparam int unsigned CB_ACT    = 4;
  localparam int unsigned CB_MUTE   = 5;
  localparam int unsigned CB_BOOTOK = 7;
  localparam logic [7:0]  CTRL_KEEP = 8'hB0;

  localparam logic [7:0] ST_NONE  = 8'd0;
  localparam logic [7:0] ST_RST   = 8'd1;
  localparam logic [7:0] ST_PWR   = 8'd2;
  localparam logic [7:0] ST_QUIET = 8'd3;

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int unsigned TICK_CYCLES = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] div_q, div_d;

  always_comb begin
    tick_o = run_i && !restart_i && (div_q == LAST);
    if (restart_i || !run_i || tick_o) div_d = '0;
    else                               div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

endmodule

// File: rtl/wdog_down.sv
module wdog_down #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             armed_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;

  always_comb begin
    expire_o = armed_q && (cnt_q == '0) && !load_i;
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    if (load_i) begin
      cnt_d   = load_val_i;
      armed_d = 1'b1;
    end else if (expire_o) begin
      armed_d = 1'b0;
    end else if (armed_q && tick_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;

  AST_COUNT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && cnt_q != '0 && !load_i && !tick_i) |=> (cnt_q == $past(cnt_q))); // R2
  AST_FIRES_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !load_i) |=> !armed_q); // R10
  AST_EXPIRE_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R10

endmodule

// File: rtl/wdog_retry.sv
module wdog_retry
  import wdog_pkg::*;
#(
  parameter int unsigned RETRY_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               act_i,
  input  logic [RETRY_W-1:0] limit_i,
  input  logic               boot_ok_i,
  input  logic               unplanned_i,
  input  logic               access_i,
  output logic               sys_rst_o,
  output logic               pwr_off_o,
  output logic [7:0]         status_o
);
  localparam logic [RETRY_W-1:0] CMAX = {RETRY_W{1'b1}};

  logic [RETRY_W-1:0] used_q, used_d;
  logic [7:0]         stat_q, stat_d;
  logic               rst_q, pwr_q, take_rst, take_pwr;

  always_comb begin
    take_rst = fire_i && act_i && (used_q < limit_i);
    take_pwr = fire_i && act_i && !(used_q < limit_i);

    used_d = used_q;
    if (boot_ok_i)                                       used_d = '0;
    else if ((take_rst || unplanned_i) && used_q != CMAX) used_d = used_q + 1'b1;

    stat_d = stat_q;
    if (fire_i)        stat_d = take_rst ? ST_RST : (take_pwr ? ST_PWR : ST_QUIET);
    else if (access_i) stat_d = ST_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      stat_q <= ST_NONE;
      rst_q  <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      used_q <= used_d;
      stat_q <= stat_d;
      rst_q  <= take_rst;
      pwr_q  <= take_pwr;
    end
  end

  assign sys_rst_o = rst_q;
  assign pwr_off_o = pwr_q;
  assign status_o  = stat_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q); // R10
  AST_PWR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q |=> !pwr_q); // R10
  AST_OUTS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rst_q && pwr_q)); // R8
  AST_RST_UNDER_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> ($past(used_q) < $past(limit_i))); // R8
  AST_PWR_OVER_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q |-> ($past(used_q) >= $past(limit_i))); // R8
  AST_STAT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> (stat_q == ST_RST)); // R11
  AST_STAT_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q |-> (stat_q == ST_PWR)); // R11
  AST_BOOT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_ok_i |=> (used_q == '0)); // R9

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 200_000_000,
  parameter int unsigned RETRY_W     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         bus_addr_i,
  input  logic               bus_we_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  input  logic [RETRY_W-1:0] retry_lim_i,
  input  logic               unplanned_rst_i,
  output logic               sys_rst_o,
  output logic               pwr_off_o
);
  localparam int unsigned DW = 8;

  logic [1:0]    rsync_q;
  logic          rst_sn;
  logic [DW-1:0] time_q, time_d, ctrl_q, ctrl_d, status;
  logic          wr_time, wr_ctrl, boot_ok, act, armed, tick, fire;
  wd_addr_e      addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  always_comb begin
    addr    = wd_addr_e'(bus_addr_i);
    wr_time = bus_we_i && (addr == WA_TIME);
    wr_ctrl = bus_we_i && (addr == WA_CTRL);
    boot_ok = wr_ctrl && bus_wdata_i[CB_BOOTOK];
    act     = ctrl_q[CB_ACT] && !ctrl_q[CB_MUTE];
    time_d  = wr_time ? bus_wdata_i : time_q;
    ctrl_d  = wr_ctrl ? (bus_wdata_i & CTRL_KEEP) : ctrl_q;
    case (addr)
      WA_TIME: bus_rdata_o = time_q;
      WA_STAT: bus_rdata_o = status;
      WA_CTRL: bus_rdata_o = ctrl_q;
      default: bus_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      time_q <= '0;
      ctrl_q <= '0;
    end else begin
      time_q <= time_d;
      ctrl_q <= ctrl_d;
    end
  end

  wdog_tick #(.TICK_CYCLES(TICK_CYCLES)) tick_i (
    .clk_i(clk_i), .rst_ni(rst_sn), .run_i(armed),
    .restart_i(wr_time), .tick_o(tick)
  );

  wdog_down #(.CNT_W(DW)) down_i (
    .clk_i(clk_i), .rst_ni(rst_sn), .load_i(wr_time),
    .load_val_i(bus_wdata_i), .tick_i(tick),
    .armed_o(armed), .expire_o(fire)
  );

  wdog_retry #(.RETRY_W(RETRY_W)) retry_i (
    .clk_i(clk_i), .rst_ni(rst_sn), .fire_i(fire), .act_i(act),
    .limit_i(retry_lim_i), .boot_ok_i(boot_ok),
    .unplanned_i(unplanned_rst_i), .access_i(bus_we_i),
    .sys_rst_o(sys_rst_o), .pwr_off_o(pwr_off_o), .status_o(status)
  );

  AST_CTRL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_sn)
    wr_ctrl |=> ((ctrl_q & ~CTRL_KEEP) == '0)); // R6
  AST_STAT_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (bus_we_i && addr == WA_STAT && !fire) |=> (status == ST_NONE)); // R5
  AST_NO_ACTION_QUIET: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (fire && !act) |=> (!sys_rst_o && !pwr_off_o)); // R7

endmodule

// File: tb/wdog_escalate_tb_top.sv
`timescale 1ns/1ps
module wdog_escalate_tb_top;
  localparam int unsigned TICK = 4;

  typedef struct packed {
    logic [1:0] a;
    logic [7:0] d;
    logic [7:0] e;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd2, 8'hFF, 8'hB0},
    '{2'd2, 8'h4F, 8'h00},
    '{2'd1, 8'h5A, 8'h00},
    '{2'd3, 8'hAA, 8'h00},
    '{2'd0, 8'h1E, 8'h1E},
    '{2'd0, 8'hFF, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [2:0] lim = 3'd2;
  logic       unpl = 1'b0;
  logic       srst, poff;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdog_escalate #(.TICK_CYCLES(TICK), .RETRY_W(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .retry_lim_i(lim),
    .unplanned_rst_i(unpl), .sys_rst_o(srst), .pwr_off_o(poff)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] e, input string tag);
    addr = a;
    #1;
    check(rdata == e, tag, rdata, e);
  endtask

  // kind: 0 none, 1 reset, 2 power-off
  task automatic arm_watch(input logic [7:0] n, input int kind, input string tag);
    int lim_c, at, seen_kind, highs;
    logic [7:0] st;
    lim_c = int'(n) * TICK + 40;
    at = -1; seen_kind = 0; highs = 0; st = 8'd0;
    @(negedge clk);
    addr = 2'd0; wdata = n; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; addr = 2'd1;
    for (int i = 0; i <= lim_c; i++) begin
      if (i > 0) @(negedge clk);
      if (srst || poff) begin
        highs++;
        if (at < 0) begin
          at = i; seen_kind = srst ? 1 : 2; st = rdata;
        end
      end
    end
    if (kind == 0) begin
      check(at < 0, {tag, " no pulse"}, at, -1);
      check(rdata == 8'd3, {tag, " R11 status quiet"}, rdata, 3);
    end else begin
      check(at == int'(n) * TICK + 1, {tag, " R2 latency"}, at, int'(n) * TICK + 1);
      check(seen_kind == kind, {tag, " R8 kind"}, seen_kind, kind);
      check(int'(st) == kind, {tag, " R11 status code"}, st, kind);
      check(highs == 1, {tag, " R10 single pulse"}, highs, 1);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check(!srst && !poff, "R12 outputs low", {srst, poff}, 0);
    for (int a = 0; a < 4; a++) rd_check(a[1:0], 8'h00, "R12 read zero");

    // Register vector table: R1 R5 R6
    foreach (VEC[k]) begin
      wr(VEC[k].a, VEC[k].d);
      rd_check(VEC[k].a, VEC[k].e, "R1/R5/R6 table readback");
    end

    // R2 R8 R11: reset with budget 2, count 0
    lim = 3'd2;
    wr(2'd2, 8'h10);
    arm_watch(8'd3, 1, "R2 n=3 reset");
    rd_check(2'd0, 8'd3, "R1 time reads written value after expiry");
    // R3 immediate
    arm_watch(8'd0, 1, "R3 n=0 reset");
    // R8 budget used up -> power-off
    arm_watch(8'd1, 2, "R8 budget spent");
    // R9 boot OK clears, R7 bit7 irrelevant
    wr(2'd2, 8'h90);
    arm_watch(8'd1, 1, "R9 after boot ok");
    // R9 unplanned resets count toward budget
    @(negedge clk); unpl = 1'b1;
    @(negedge clk); @(negedge clk); unpl = 1'b0;
    arm_watch(8'd0, 2, "R9 unplanned counted");
    // R7 mute suppresses
    wr(2'd2, 8'h30);
    arm_watch(8'd2, 0, "R7 mute");
    wr(2'd2, 8'h10);
    rd_check(2'd1, 8'd0, "R11 status clears on access");
    // R4 servicing
    wr(2'd2, 8'h90);
    begin
      int early;
      early = 0;
      wr(2'd0, 8'd2);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (srst || poff) early++;
      end
      check(early == 0, "R4 no pulse before reload", early, 0);
    end
    arm_watch(8'd2, 1, "R4 reload restarts");
    // R8 limit 0 always power-off
    lim = 3'd0;
    wr(2'd2, 8'h90);
    arm_watch(8'd0, 2, "R8 limit zero");
    // R7 act clear
    lim = 3'd7;
    wr(2'd2, 8'h00);
    arm_watch(8'd0, 0, "R7 act clear");
    rd_check(2'd0, 8'd0, "R1 time readback zero");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule